// File: doc/BRIEF.md
# Two-Slot Elastic Buffer Stage

This block is one stage of a flow-controlled pipeline. Words arrive on an upstream port with valid, ready and data signals and leave on a downstream port with the same three signals. Two storage slots sit between the ports. The outgoing valid and data come from storage registers. The upstream ready comes from registered slot-occupancy flags. As a result, no combinational path runs through the stage in either direction. The stage can therefore be placed on long links to cut timing paths on both the data wires and the backpressure wire.

Each slot is a single-word, half-rate cell with its own full flag. Either slot alone would carry at most one word every other cycle. Paired, they still accept one word and deliver one word per cycle in steady state. The parameter `ARCH` picks one of two ways to pair the cells:

- **Chained**: an output cell is backed by a spill cell that fills only when the output cell stalls.
- **Interleaved**: write and read pointers alternate between the two cells.

Both choices behave the same at the ports.

Top module: `elastic_pair_buf`

## Requirements
- R1: Synchronous active-high reset empties both slots: in the cycle after reset is seen, `dn_valid` is 0 and `up_ready` is 1.
- R2: A word is taken from the upstream port only in a cycle where `up_valid` and `up_ready` are both 1. Data offered at other times never appears downstream.
- R3: No word is lost or duplicated: the sequence of words delivered downstream equals the sequence accepted upstream, in the same order, under any pattern of `up_valid` and `dn_ready`.
- R4: With `up_valid` and `dn_ready` held at 1, the stage delivers one word in every cycle after the first.
- R5: A word accepted into an empty stage is presented on `dn_valid`/`dn_data` in the next cycle (forward latency one cycle). `dn_valid` is 1 exactly when at least one word is stored.
- R6: `up_ready` is 0 exactly when two words are stored. It does not rise in a cycle that follows a cycle with no downstream transfer (backward latency one cycle).
- R7: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` stays 1 and `dn_data` stays unchanged in the next cycle.
- R8: With `dn_ready` held at 0, the stage accepts exactly two words and then holds `up_ready` at 0.
- R9: Both values of `ARCH` (chained and interleaved) give identical port behaviour for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream word offered |
| up_ready | output | 1 | Stage can take a word (registered) |
| up_data | input | DATA_W | Upstream word |
| dn_valid | output | 1 | Stage presents a word (registered) |
| dn_ready | input | 1 | Downstream takes the presented word |
| dn_data | output | DATA_W | Presented word (registered) |

## Verification
The critical coincidence is an upstream acceptance and a downstream delivery in the same cycle. With one word stored, this means the slot being emptied and the slot being filled must be told apart. With two words stored in the chained form, the spill cell drains into the output cell in that same cycle. The bench provokes the coincidence by sweeping every pair of 4-cycle repeating patterns on `up_valid` and `dn_ready`. It judges each cycle against an arithmetic occupancy model: expected valid, ready and data are computed from counts of words sent and received. Both variants of `ARCH` run side by side under the same stimulus.

// File: rtl/epb_pkg.sv
package epb_pkg;

   // Pairing of the two half-rate cells
   typedef enum logic [0:0] {
      EPB_CHAIN = 1'b0,   // output cell backed by a spill cell
      EPB_RING  = 1'b1    // alternating write/read pointers
   } epb_arch_e;

   localparam int unsigned EPB_SLOTS = 2;

   function automatic logic epb_fire(input logic valid, input logic ready);
      return valid & ready;
   endfunction

endpackage

// File: rtl/epb_slot.sv
module epb_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
      end else if (wr_en) begin
         full_q <= 1'b1;
      end else if (rd_en) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         data_q <= wr_data;
      end
   end

   assign full = full_q;
   assign data = data_q;

   // R3
   no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (!full_q || rd_en));

   // R3
   no_phantom_read_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> full_q);

endmodule

// File: rtl/epb_chain_ctrl.sv
module epb_chain_ctrl #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data
);

   import epb_pkg::*;

   logic              out_full, spill_full;
   logic [DATA_W-1:0] out_data, spill_data;
   logic              in_fire, out_fire;
   logic              out_free;
   logic              out_wr, spill_wr, spill_rd;
   logic [DATA_W-1:0] out_wdata;

   assign up_ready = !spill_full;
   assign dn_valid = out_full;
   assign dn_data  = out_data;

   assign in_fire  = epb_fire(up_valid, up_ready);
   assign out_fire = epb_fire(out_full, dn_ready);

   // output cell can take a word if empty or being emptied this cycle
   assign out_free  = !out_full || out_fire;
   assign out_wr    = out_free && (spill_full || in_fire);
   assign out_wdata = spill_full ? spill_data : up_data;
   assign spill_rd  = out_free && spill_full;
   assign spill_wr  = in_fire && out_full && !out_fire;

   epb_slot #(.DATA_W(DATA_W)) i_out_cell (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (out_wr),
      .wr_data (out_wdata),
      .rd_en   (out_fire),
      .full    (out_full),
      .data    (out_data)
   );

   epb_slot #(.DATA_W(DATA_W)) i_spill_cell (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (spill_wr),
      .wr_data (up_data),
      .rd_en   (spill_rd),
      .full    (spill_full),
      .data    (spill_data)
   );

   // R2
   spill_behind_out_chk: assert property (@(posedge clk) disable iff (rst)
      spill_full |-> out_full);

   // R3
   spill_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (spill_full && dn_ready) |=> (out_full && !spill_full));

endmodule

// File: rtl/epb_ring_ctrl.sv
module epb_ring_ctrl #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data
);

   import epb_pkg::*;

   localparam int unsigned PTR_W = $clog2(EPB_SLOTS);

   logic [EPB_SLOTS-1:0] cell_full;
   logic [DATA_W-1:0]    cell_data [EPB_SLOTS];
   logic [PTR_W-1:0]     wr_ptr_q, rd_ptr_q;
   logic                 in_fire, out_fire;

   assign up_ready = !cell_full[wr_ptr_q];
   assign dn_valid = cell_full[rd_ptr_q];
   assign dn_data  = cell_data[rd_ptr_q];

   assign in_fire  = epb_fire(up_valid, up_ready);
   assign out_fire = epb_fire(dn_valid, dn_ready);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
      end else begin
         if (in_fire) begin
            wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         end
         if (out_fire) begin
            rd_ptr_q <= rd_ptr_q + PTR_W'(1);
         end
      end
   end

   for (genvar s = 0; s < EPB_SLOTS; s++) begin : g_cell
      logic cell_wr, cell_rd;
      assign cell_wr = in_fire  && (wr_ptr_q == PTR_W'(s));
      assign cell_rd = out_fire && (rd_ptr_q == PTR_W'(s));

      epb_slot #(.DATA_W(DATA_W)) i_cell (
         .clk     (clk),
         .rst     (rst),
         .wr_en   (cell_wr),
         .wr_data (up_data),
         .rd_en   (cell_rd),
         .full    (cell_full[s]),
         .data    (cell_data[s])
      );
   end

   // R3
   ptr_order_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ptr_q == rd_ptr_q) |-> (cell_full == '0 || cell_full == '1));

endmodule

// File: rtl/elastic_pair_buf.sv
module elastic_pair_buf
   import epb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter epb_arch_e   ARCH   = EPB_CHAIN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data
);

   if (DATA_W < 1) begin : g_bad_width
      $error("elastic_pair_buf: DATA_W must be at least 1");
   end

   if (ARCH == EPB_CHAIN) begin : g_chain
      epb_chain_ctrl #(.DATA_W(DATA_W)) i_ctrl (
         .clk      (clk),
         .rst      (rst),
         .up_valid (up_valid),
         .up_ready (up_ready),
         .up_data  (up_data),
         .dn_valid (dn_valid),
         .dn_ready (dn_ready),
         .dn_data  (dn_data)
      );
   end else begin : g_ring
      epb_ring_ctrl #(.DATA_W(DATA_W)) i_ctrl (
         .clk      (clk),
         .rst      (rst),
         .up_valid (up_valid),
         .up_ready (up_ready),
         .up_data  (up_data),
         .dn_valid (dn_valid),
         .dn_ready (dn_ready),
         .dn_data  (dn_data)
      );
   end

   // independent occupancy tracker used only by the checks below
   logic [1:0] occ_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         occ_q <= 2'd0;
      end else begin
         occ_q <= occ_q + 2'(up_valid && up_ready) - 2'(dn_valid && dn_ready);
      end
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!dn_valid && up_ready));

   // R7
   hold_word_chk: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

   // R8
   occ_limit_chk: assert property (@(posedge clk) disable iff (rst)
      occ_q != 2'd3);

   // R6
   ready_map_chk: assert property (@(posedge clk) disable iff (rst)
      up_ready == (occ_q != 2'd2));

   // R5
   valid_map_chk: assert property (@(posedge clk) disable iff (rst)
      dn_valid == (occ_q != 2'd0));

   // R6
   ready_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (!up_ready && !(dn_valid && dn_ready)) |=> !up_ready);

endmodule

// File: tb/test_elastic_pair_buf.sv
`timescale 1ns/1ps
module test_elastic_pair_buf;
   import epb_pkg::*;

   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          up_valid = 1'b0;
   logic          dn_ready = 1'b0;
   logic [DW-1:0] up_data = '0;
   logic          c_up_ready, c_dn_valid, r_up_ready, r_dn_valid;
   logic [DW-1:0] c_dn_data, r_dn_data;

   int checks = 0;
   int errors = 0;
   int sent = 0;
   int rcvd = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   elastic_pair_buf #(.DATA_W(DW), .ARCH(EPB_CHAIN)) i_elastic_pair_buf (
      .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(c_up_ready),
      .up_data(up_data), .dn_valid(c_dn_valid), .dn_ready(dn_ready),
      .dn_data(c_dn_data));

   elastic_pair_buf #(.DATA_W(DW), .ARCH(EPB_RING)) i_elastic_pair_buf_ring (
      .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(r_up_ready),
      .up_data(up_data), .dn_valid(r_dn_valid), .dn_ready(dn_ready),
      .dn_data(r_dn_data));

   function automatic logic [DW-1:0] word_of(input int i);
      return DW'((i * 59) ^ 90);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // called at a negedge: compare outputs with model, drive one cycle
   task automatic step(input bit v, input bit r);
      bit exp_v, exp_r;
      exp_v = (sent - rcvd) > 0;
      exp_r = (sent - rcvd) < 2;
      check(c_dn_valid == exp_v, "R5 chain dn_valid", int'(c_dn_valid), int'(exp_v));
      check(c_up_ready == exp_r, "R6/R8 chain up_ready", int'(c_up_ready), int'(exp_r));
      check(r_dn_valid == exp_v, "R9 ring dn_valid", int'(r_dn_valid), int'(exp_v));
      check(r_up_ready == exp_r, "R9 ring up_ready", int'(r_up_ready), int'(exp_r));
      if (exp_v) begin
         check(c_dn_data == word_of(rcvd), "R2/R3 chain dn_data", int'(c_dn_data), int'(word_of(rcvd)));
         check(r_dn_data == word_of(rcvd), "R9 ring dn_data", int'(r_dn_data), int'(word_of(rcvd)));
      end
      up_valid = v;
      dn_ready = r;
      up_data  = v ? word_of(sent) : ~word_of(sent + 7);
      @(posedge clk);
      if (v && exp_r) sent++;
      if (r && exp_v) rcvd++;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      up_valid = 1'b0;
      dn_ready = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      sent = 0;
      rcvd = 0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seen;
      @(negedge clk);
      do_reset();
      // R1: reset state
      check(!c_dn_valid && c_up_ready, "R1 chain reset", int'(c_dn_valid), 0);
      check(!r_dn_valid && r_up_ready, "R1 ring reset", int'(r_dn_valid), 0);

      // R8: downstream stalled, exactly two words accepted
      for (int c = 0; c < 5; c++) step(1'b1, 1'b0);
      check(sent == 2, "R8 capacity", sent, 2);
      check(!c_up_ready && !r_up_ready, "R8 ready held low", int'(c_up_ready), 0);

      // R6: ready rises one cycle after a delivery, not in the same cycle
      dn_ready = 1'b1;
      up_valid = 1'b0;
      check(!c_up_ready && !r_up_ready, "R6 same cycle ready", int'(c_up_ready), 0);
      @(posedge clk); rcvd++;
      @(negedge clk);
      check(c_up_ready && r_up_ready, "R6 ready after one cycle", int'(c_up_ready), 1);
      for (int c = 0; c < 3; c++) step(1'b0, 1'b1);

      // R1: reset while full
      for (int c = 0; c < 3; c++) step(1'b1, 1'b0);
      do_reset();
      check(!c_dn_valid && c_up_ready, "R1 chain reset when full", int'(c_dn_valid), 0);
      check(!r_dn_valid && r_up_ready, "R1 ring reset when full", int'(r_dn_valid), 0);

      // R5: forward latency of one cycle from empty
      step(1'b1, 1'b0);
      check(c_dn_valid && c_dn_data == word_of(0), "R5 chain latency", int'(c_dn_data), int'(word_of(0)));
      check(r_dn_valid && r_dn_data == word_of(0), "R5 ring latency", int'(r_dn_data), int'(word_of(0)));
      for (int c = 0; c < 3; c++) step(1'b0, 1'b1);

      // R4: full throughput
      seen = 0;
      for (int c = 0; c < 20; c++) begin
         if (c_dn_valid && r_dn_valid) seen++;
         step(1'b1, 1'b1);
      end
      check(seen == 19, "R4 throughput", seen, 19);
      check(sent - rcvd == 1, "R4 occupancy", sent - rcvd, 1);
      for (int c = 0; c < 3; c++) step(1'b0, 1'b1);

      // R2 R3 R7 R9: sweep of all 4-cycle valid/ready pattern pairs
      for (int vp = 0; vp < 16; vp++) begin
         for (int rp = 0; rp < 16; rp++) begin
            for (int c = 0; c < 16; c++) begin
               step(vp[c % 4], rp[(c + vp) % 4]);
            end
            for (int c = 0; c < 3; c++) step(1'b0, 1'b1);
            check(sent == rcvd, "R3 drained count", rcvd, sent);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule